// File: doc/BRIEF.md
# IDE Controller Register Front-End

This block sits between a memory-mapped host bus and a two-drive IDE task-file engine. It takes one request at a time on a 4 KiB little-endian window, extracts a register index from the address, and applies the access-size rule for that register. Legal data-port, task-file, status and command accesses go to a task-file port. Every other access is absorbed locally.

Two registers are local to the block. The first is a 32-bit drive timing word, which only stores the value written to it. The second is an interrupt-state word, in which two bits track a DMA interrupt line and a disk interrupt line. Software acknowledges the DMA bit by writing a one to it. Both interrupt lines are also passed straight through to their own outputs.

A read is answered on the cycle after it is accepted, with registered data. The task-file engine must return its read data combinationally in the cycle the request is presented.

Top module: `ide_reg_frontend`

## Requirements
- R1: The register index is `req_addr[11:4]`, so registers are spaced 16 bytes apart. Address bits 3:0 never change the result. `req_size` carries the access width as a byte count (1, 2, 3 or 4).
- R2: Index 0 is the data port. It is forwarded with `tf_kind`=0 only for 2-byte or 4-byte accesses. A 2-byte read returns `tf_rdata[15:0]` zero-extended, and a 4-byte read returns all of `tf_rdata`.
- R3: Indices 1 to 7 are task-file registers. They are forwarded with `tf_kind`=1 and `tf_idx` equal to the index, but only for 1-byte accesses. A byte read returns `tf_rdata[7:0]` zero-extended.
- R4: Indices 0x08 and 0x16 both select the status/command port. A 1-byte access is forwarded with `tf_kind`=2 and `tf_idx`=0. A read returns device status in the low byte, and a write carries a command.
- R5: Index 0x20 holds a 32-bit timing word, which is read and written only with 4-byte accesses. Writes of any other size leave it unchanged, and it is 0 after reset.
- R6: Index 0x30 reads the interrupt-state word, with 4-byte accesses only. Bit 31 takes the DMA line's level and bit 30 takes the disk line's level on every change of that line. All other bits read 0, and the word is 0 after reset.
- R7: A 4-byte write to index 0x30 with bit 31 set clears bit 31 and leaves bit 30 unchanged. Such a write with bit 31 clear, or of any other size, changes nothing. A change of the DMA line in the same cycle takes precedence over the clear.
- R8: `irq_dma_out` follows `irq_dma_in` and `irq_disk_out` follows `irq_disk_in` in the same cycle. Both outputs are held low while reset is asserted.
- R9: A read from an unmapped index, or with a size the register does not accept, returns 0xFFFFFFFF. Such a write has no effect. In both cases `tf_req` stays low.
- R10: `req_ready` is high whenever reset is low. An accepted read produces `rsp_valid` for exactly one cycle, on the cycle after acceptance. A write never produces a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the window |
| req_size | input | 3 | Access width in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| tf_req | output | 1 | Access forwarded to the task-file engine |
| tf_we | output | 1 | Forwarded access is a write |
| tf_kind | output | 2 | 0 data port, 1 task-file register, 2 status/command |
| tf_idx | output | 3 | Task-file register number (1 to 7) |
| tf_size | output | 3 | Forwarded access width in bytes |
| tf_wdata | output | 32 | Forwarded write data |
| tf_rdata | input | 32 | Read data from the task-file engine, same cycle |
| irq_dma_in | input | 1 | DMA interrupt line |
| irq_disk_in | input | 1 | Disk interrupt line |
| irq_dma_out | output | 1 | DMA interrupt to the host |
| irq_disk_out | output | 1 | Disk interrupt to the host |

## Verification
The assertions check the following properties on every cycle:
- The interrupt pass-through.
- The one-cycle read response and the absence of responses to writes.
- That nothing reaches the task-file port without a host request or at a forbidden size.
- That the timing word holds between legal writes.
- That the DMA bit sets on a rising line and clears on an acknowledge.

The bench's sweeps over every index, every size and both directions are what show the decode itself: the exact data returned, the zero-extension, and the 0xFFFFFFFF default. The scenarios also show the write-clear leaving the disk bit alone, and the reset values.

// File: rtl/ide_fe_pkg.sv
package ide_fe_pkg;

    localparam int WORD_W = 32;

    localparam logic [7:0] IDX_DATA    = 8'h00;
    localparam logic [7:0] IDX_STAT_LO = 8'h08;
    localparam logic [7:0] IDX_STAT_HI = 8'h16;
    localparam logic [7:0] IDX_TIMING  = 8'h20;
    localparam logic [7:0] IDX_IRQ     = 8'h30;

    localparam int DMA_BIT  = 31;
    localparam int DISK_BIT = 30;

    typedef enum logic [1:0] {
        TF_DATA    = 2'd0,
        TF_TASK    = 2'd1,
        TF_STATCMD = 2'd2
    } tf_kind_e;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_TF     = 2'd1,
        ACC_TIMING = 2'd2,
        ACC_IRQ    = 2'd3
    } acc_e;

    typedef struct packed {
        acc_e     acc;
        tf_kind_e kind;
        logic [2:0] tf_idx;
    } dec_t;

    // Zero-extend task-file read data to the width of the access.
    function automatic logic [WORD_W-1:0] fit_read(input logic [2:0] size,
                                                   input logic [WORD_W-1:0] d);
        logic [WORD_W-1:0] r;
        case (size)
            3'd1:    r = {{(WORD_W-8){1'b0}}, d[7:0]};
            3'd2:    r = {{(WORD_W-16){1'b0}}, d[15:0]};
            default: r = d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ide_fe_decode.sv
module ide_fe_decode
    import ide_fe_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [2:0]       size,
    output dec_t             dec
);
    logic [7:0] idx8;
    logic       is_byte, is_word, is_half;

    generate
        if (IDX_W >= 8) begin : g_trunc
            assign idx8 = (idx >> 8 == '0) ? idx[7:0] : 8'hFF;
        end else begin : g_ext
            assign idx8 = {{(8-IDX_W){1'b0}}, idx};
        end
    endgenerate

    assign is_byte = (size == 3'd1);
    assign is_half = (size == 3'd2);
    assign is_word = (size == 3'd4);

    always_comb begin
        dec = '{acc: ACC_NONE, kind: TF_DATA, tf_idx: 3'd0};
        if (idx8 == IDX_DATA && (is_half || is_word)) begin
            dec.acc  = ACC_TF;
            dec.kind = TF_DATA;
        end else if (idx8 >= 8'd1 && idx8 <= 8'd7 && is_byte) begin
            dec.acc    = ACC_TF;
            dec.kind   = TF_TASK;
            dec.tf_idx = idx8[2:0];
        end else if ((idx8 == IDX_STAT_LO || idx8 == IDX_STAT_HI) && is_byte) begin
            dec.acc  = ACC_TF;
            dec.kind = TF_STATCMD;
        end else if (idx8 == IDX_TIMING && is_word) begin
            dec.acc = ACC_TIMING;
        end else if (idx8 == IDX_IRQ && is_word) begin
            dec.acc = ACC_IRQ;
        end
    end
endmodule

// File: rtl/ide_fe_irq.sv
module ide_fe_irq
    import ide_fe_pkg::*;
#(
    parameter int N_LINES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] lines,
    input  logic               clr_top,
    output logic [WORD_W-1:0]  word
);
    logic [N_LINES-1:0] prev_q;
    logic [N_LINES-1:0] bits_q;

    generate
        for (genvar g = 0; g < N_LINES; g++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q[g] <= 1'b0;
                    bits_q[g] <= 1'b0;
                end else begin
                    prev_q[g] <= lines[g];
                    if (lines[g] != prev_q[g]) begin
                        bits_q[g] <= lines[g];
                    end else if (g == 0 && clr_top) begin
                        bits_q[g] <= 1'b0;
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        word = '0;
        for (int n = 0; n < N_LINES; n++) begin
            word[WORD_W-1-n] = bits_q[n];
        end
    end
endmodule

// File: rtl/ide_fe_timing.sv
module ide_fe_timing
    import ide_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (wr_en) begin
            value <= wr_data;
        end
    end
endmodule

// File: rtl/ide_reg_frontend.sv
module ide_reg_frontend
    import ide_fe_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int IDX_LSB = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              tf_req,
    output logic              tf_we,
    output logic [1:0]        tf_kind,
    output logic [2:0]        tf_idx,
    output logic [2:0]        tf_size,
    output logic [31:0]       tf_wdata,
    input  logic [31:0]       tf_rdata,
    input  logic              irq_dma_in,
    input  logic              irq_disk_in,
    output logic              irq_dma_out,
    output logic              irq_disk_out
);
    localparam int IDX_W = ADDR_W - IDX_LSB;

    dec_t              dec;
    logic              accept;
    logic              rd_acc;
    logic              wr_acc;
    logic [WORD_W-1:0] timing_value;
    logic [WORD_W-1:0] irq_word;
    logic [WORD_W-1:0] rd_mux;
    logic              irq_clr;

    assign req_ready = !rst;
    assign accept    = req_valid && req_ready;
    assign rd_acc    = accept && !req_write;
    assign wr_acc    = accept && req_write;

    ide_fe_decode #(.IDX_W(IDX_W)) u_decode (
        .idx  (req_addr[ADDR_W-1:IDX_LSB]),
        .size (req_size),
        .dec  (dec)
    );

    ide_fe_timing u_timing (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_acc && dec.acc == ACC_TIMING),
        .wr_data (req_wdata),
        .value   (timing_value)
    );

    assign irq_clr = wr_acc && dec.acc == ACC_IRQ && req_wdata[DMA_BIT];

    ide_fe_irq #(.N_LINES(2)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .lines   ({irq_disk_in, irq_dma_in}),
        .clr_top (irq_clr),
        .word    (irq_word)
    );

    // Task-file forwarding
    assign tf_req   = accept && dec.acc == ACC_TF;
    assign tf_we    = req_write;
    assign tf_kind  = dec.kind;
    assign tf_idx   = dec.tf_idx;
    assign tf_size  = req_size;
    assign tf_wdata = req_wdata;

    always_comb begin
        case (dec.acc)
            ACC_TF:     rd_mux = fit_read(req_size, tf_rdata);
            ACC_TIMING: rd_mux = timing_value;
            ACC_IRQ:    rd_mux = irq_word;
            default:    rd_mux = '1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_acc;
            if (rd_acc) begin
                rsp_rdata <= rd_mux;
            end
        end
    end

    assign irq_dma_out  = irq_dma_in && !rst;
    assign irq_disk_out = irq_disk_in && !rst;
endmodule

// File: rtl/ide_fe_checker.sv
module ide_fe_checker #(
    parameter int ADDR_W  = 12,
    parameter int IDX_LSB = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [2:0]        req_size,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic              tf_req,
    input logic [1:0]        tf_kind,
    input logic              irq_dma_in,
    input logic              irq_disk_in,
    input logic              irq_dma_out,
    input logic              irq_disk_out,
    input logic [31:0]       irq_word,
    input logic [31:0]       timing_value
);
    logic rd_acc, wr_acc, tim_wr, irq_wr_clr;
    assign rd_acc     = req_valid && req_ready && !req_write;
    assign wr_acc     = req_valid && req_ready && req_write;
    assign tim_wr     = wr_acc && req_addr[ADDR_W-1:IDX_LSB] == 8'h20 && req_size == 3'd4;
    assign irq_wr_clr = wr_acc && req_addr[ADDR_W-1:IDX_LSB] == 8'h30 && req_size == 3'd4
                        && req_wdata[31];

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        rd_acc |=> rsp_valid); // R10
    AST_NO_RSP_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write) |=> !rsp_valid); // R10
    AST_READY_OUT_OF_RESET: assert property (@(posedge clk) disable iff (rst)
        req_ready); // R10
    AST_TF_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        tf_req |-> req_valid); // R9
    AST_TASK_BYTE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (tf_req && tf_kind != 2'd0) |-> req_size == 3'd1); // R3
    AST_DATA_SIZE: assert property (@(posedge clk) disable iff (rst)
        (tf_req && tf_kind == 2'd0) |-> (req_size == 3'd2 || req_size == 3'd4)); // R2
    AST_DMA_PASS: assert property (@(posedge clk) disable iff (rst)
        irq_dma_out == irq_dma_in); // R8
    AST_DISK_PASS: assert property (@(posedge clk) disable iff (rst)
        irq_disk_out == irq_disk_in); // R8
    AST_TIMING_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tim_wr |=> $stable(timing_value)); // R5
    AST_DMA_SET: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_dma_in) |=> irq_word[31]); // R6
    AST_DMA_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (irq_wr_clr && !irq_dma_in) |=> !irq_word[31]); // R7
    AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        irq_word[29:0] == 30'd0); // R6
endmodule

bind ide_reg_frontend ide_fe_checker #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_size     (req_size),
    .req_wdata    (req_wdata),
    .rsp_valid    (rsp_valid),
    .tf_req       (tf_req),
    .tf_kind      (tf_kind),
    .irq_dma_in   (irq_dma_in),
    .irq_disk_in  (irq_disk_in),
    .irq_dma_out  (irq_dma_out),
    .irq_disk_out (irq_disk_out),
    .irq_word     (irq_word),
    .timing_value (timing_value)
);

// File: tb/tb_ide_reg_frontend.sv
module tb_ide_reg_frontend;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [2:0]  req_size = 3'd1;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        tf_req, tf_we;
    logic [1:0]  tf_kind;
    logic [2:0]  tf_idx, tf_size;
    logic [31:0] tf_wdata, tf_rdata;
    logic        irq_dma_in = 1'b0, irq_disk_in = 1'b0;
    logic        irq_dma_out, irq_disk_out;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m_timing = '0;
    logic [31:0] m_irq = '0;

    always #4 clk = ~clk;

    // Task-file engine stand-in: returns a code of the selected register.
    assign tf_rdata = {16'hBEEF, 8'h5A, 3'b000, tf_kind, tf_idx};

    ide_reg_frontend dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .tf_req(tf_req), .tf_we(tf_we), .tf_kind(tf_kind), .tf_idx(tf_idx),
        .tf_size(tf_size), .tf_wdata(tf_wdata), .tf_rdata(tf_rdata),
        .irq_dma_in(irq_dma_in), .irq_disk_in(irq_disk_in),
        .irq_dma_out(irq_dma_out), .irq_disk_out(irq_disk_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected forwarding: {fwd, kind, idx} per requirements R2..R4, R9.
    function automatic logic [5:0] exp_fwd(input int idx, input int size);
        if (idx == 0 && (size == 2 || size == 4)) return {1'b1, 2'd0, 3'd0};
        if (idx >= 1 && idx <= 7 && size == 1) return {1'b1, 2'd1, 3'(idx)};
        if ((idx == 8 || idx == 22) && size == 1) return {1'b1, 2'd2, 3'd0};
        return 6'd0;
    endfunction

    function automatic logic [31:0] exp_read(input int idx, input int size);
        logic [5:0]  f;
        logic [31:0] raw;
        f = exp_fwd(idx, size);
        if (f[5]) begin
            raw = {16'hBEEF, 8'h5A, 3'b000, f[4:0]};
            if (size == 1) return {24'd0, raw[7:0]};
            if (size == 2) return {16'd0, raw[15:0]};
            return raw;
        end
        if (idx == 32 && size == 4) return m_timing;
        if (idx == 48 && size == 4) return m_irq;
        return 32'hFFFF_FFFF;
    endfunction

    // One access; tf outputs sampled mid-cycle, response on the next low phase.
    task automatic access(input logic wr, input logic [11:0] a, input int size,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output logic [5:0] fwd, output logic rv);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        req_size = 3'(size); req_wdata = wd;
        #1;
        fwd = tf_req ? {1'b1, tf_kind, tf_idx} : 6'd0;
        @(negedge clk);
        req_valid = 1'b0;
        rd = rsp_rdata;
        rv = rsp_valid;
    endtask

    task automatic rd_reg(input logic [11:0] a, input int size, output logic [31:0] rd);
        logic [5:0] f;
        logic rv;
        access(1'b0, a, size, 32'd0, rd, f, rv);
    endtask

    task automatic wr_reg(input logic [11:0] a, input int size, input logic [31:0] wd);
        logic [5:0] f;
        logic rv;
        logic [31:0] rd;
        access(1'b1, a, size, wd, rd, f, rv);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [5:0]  f;
        logic        rv;
        // R8: outputs held low in reset even with lines high
        irq_dma_in = 1'b1; irq_disk_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 dma out in reset", {31'd0, irq_dma_out}, 32'd0);
        check("R8 disk out in reset", {31'd0, irq_disk_out}, 32'd0);
        check("R10 ready low in reset", {31'd0, req_ready}, 32'd0);
        irq_dma_in = 1'b0; irq_disk_in = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 ready after reset", {31'd0, req_ready}, 32'd1);

        rd_reg(12'h200, 4, rd);
        check("R5 timing reset", rd, 32'd0);
        rd_reg(12'h300, 4, rd);
        check("R6 irq word reset", rd, 32'd0);

        // Write sweep: every index, sizes 1..4, varied low address bits (R1)
        for (int idx = 0; idx < 256; idx++) begin
            for (int sz = 1; sz <= 4; sz++) begin
                logic [31:0] wd;
                wd = 32'h0000_1200 + 32'(idx * 4 + sz);
                access(1'b1, {8'(idx), 4'((idx * 3 + sz) & 15)}, sz, wd, rd, f, rv);
                check("R1 R9 write forward", {26'd0, f}, {26'd0, exp_fwd(idx, sz)});
                check("R10 no write response", {31'd0, rv}, 32'd0);
                if (idx == 32 && sz == 4) m_timing = wd;
            end
        end
        // R5: only the 4-byte write took effect
        rd_reg(12'h20C, 4, rd);
        check("R5 timing after sweep", rd, m_timing);

        // Read sweep
        for (int idx = 0; idx < 256; idx++) begin
            for (int sz = 1; sz <= 4; sz++) begin
                access(1'b0, {8'(idx), 4'((idx * 5 + sz) & 15)}, sz, 32'd0, rd, f, rv);
                check("R2 R3 R4 R9 read data", rd, exp_read(idx, sz));
                check("R10 read response", {31'd0, rv}, 32'd1);
                check("R3 read forward", {26'd0, f}, {26'd0, exp_fwd(idx, sz)});
            end
        end

        // R5: sub-word writes ignored, word write stored
        wr_reg(12'h200, 2, 32'hDEAD_0000);
        wr_reg(12'h200, 1, 32'h0000_00AA);
        rd_reg(12'h200, 4, rd);
        check("R5 narrow writes ignored", rd, m_timing);
        wr_reg(12'h208, 4, 32'hCAFE_F00D);
        rd_reg(12'h200, 4, rd);
        check("R5 word write", rd, 32'hCAFE_F00D);

        // R6 / R8: interrupt tracking
        @(negedge clk); irq_dma_in = 1'b1;
        #1 check("R8 dma pass", {31'd0, irq_dma_out}, 32'd1);
        rd_reg(12'h300, 4, rd);
        check("R6 dma bit set", rd, 32'h8000_0000);
        @(negedge clk); irq_disk_in = 1'b1;
        #1 check("R8 disk pass", {31'd0, irq_disk_out}, 32'd1);
        rd_reg(12'h300, 4, rd);
        check("R6 both bits", rd, 32'hC000_0000);

        // R7: write-clear variants
        wr_reg(12'h300, 4, 32'h7FFF_FFFF);
        rd_reg(12'h300, 4, rd);
        check("R7 bit31 clear write no effect", rd, 32'hC000_0000);
        wr_reg(12'h300, 1, 32'hFFFF_FFFF);
        rd_reg(12'h300, 4, rd);
        check("R7 byte write no effect", rd, 32'hC000_0000);
        wr_reg(12'h300, 4, 32'h8000_0000);
        rd_reg(12'h300, 4, rd);
        check("R7 clear keeps disk bit", rd, 32'h4000_0000);
        check("R8 dma out stays high", {31'd0, irq_dma_out}, 32'd1);

        // R6: line falling clears its bit, rising sets it again
        @(negedge clk); irq_disk_in = 1'b0; irq_dma_in = 1'b0;
        rd_reg(12'h300, 4, rd);
        check("R6 lines low", rd, 32'h0000_0000);
        @(negedge clk); irq_dma_in = 1'b1;
        rd_reg(12'h300, 2, rd);
        check("R9 irq half read", rd, 32'hFFFF_FFFF);
        rd_reg(12'h300, 4, rd);
        check("R6 dma re-set", rd, 32'h8000_0000);

        // R7: change of the line in the same cycle as the clear wins
        @(negedge clk);
        irq_dma_in = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h300;
        req_size = 3'd4; req_wdata = 32'h8000_0000;
        irq_dma_in = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rd_reg(12'h300, 4, rd);
        check("R7 line change beats clear", rd, 32'h8000_0000);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule